// File: doc/BRIEF.md
# Four-Input Lookup Logic Cell

This block is one configurable logic cell of the kind tiled across a small programmable fabric. A 16-bit truth table, held in the configuration word, turns the four data inputs into any Boolean function of them. When the cell is put in arithmetic mode, the table is bypassed. The cell then computes a one-bit sum or difference of data inputs 0 and 1 through a carry-select stage, which also produces a carry for the next cell up the chain.

A programmable flip-flop can hold the combinational result. Its clock, clock enable and asynchronous clear are each picked by configuration from a pair of signals shared by the whole group of cells. Group-wide lines also give it a synchronous clear, a synchronous load from data input 2, and one asynchronous line. Configuration makes that line either a preset or an asynchronous load of data input 3. A configuration bit chooses whether the cell's main output carries the combinational or the registered value. The carry-out and both raw results are also brought out.

Top module: `lut_cell`

## Requirements
- R1: With cfg[16]=0, comb_o equals bit {din[3],din[2],din[1],din[0]} of the truth table cfg[15:0], with din[3] as the most significant index bit.
- R2: With cfg[16]=1 and sub_mode=0, comb_o is din[0] XOR din[1] XOR c, and cout_o is the majority of din[0], din[1] and c. Here c is the effective carry-in (the cin port when cfg[17]=0).
- R3: With sub_mode=1 the second operand din[1] is inverted before the sum and carry are formed.
- R4: With cfg[17]=1 the cell is the first stage of a chain. The cin port is then ignored and the effective carry-in equals sub_mode (0 for add, 1 for subtract).
- R5: On a rising edge of the selected clock, reg_o takes comb_o when the selected enable is high and holds when it is low. cfg[19]=0 picks ena0 and cfg[19]=1 picks ena1.
- R6: cfg[18]=0 clocks the register from clk0 and cfg[18]=1 from clk1. Edges of the unselected clock do not change reg_o.
- R7: The selected clear (cfg[20]=0 picks aclr0, 1 picks aclr1) forces reg_o to 0 at once and holds it there. The unselected clear has no effect. The clear overrides every other register control.
- R8: While aload is high and the selected clear is low, reg_o is 1 when cfg[21]=0 (preset), or equals din[3] when cfg[21]=1 (asynchronous load). This takes effect without a clock edge.
- R9: sclr high at a clock edge gives reg_o=0 whatever the enable, and it wins over sload.
- R10: sload high at a clock edge (without sclr) loads din[2] whatever the enable, and it wins over normal capture.
- R11: cell_o equals reg_o when cfg[22]=1 and comb_o when cfg[22]=0.
- R12: rst high at a clock edge of the selected clock gives reg_o=0. It ranks below the asynchronous controls and above sclr and sload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk0 | input | 1 | Group clock 0 |
| clk1 | input | 1 | Group clock 1 |
| rst | input | 1 | Synchronous active-high reset of the register |
| ena0 | input | 1 | Group clock enable 0 |
| ena1 | input | 1 | Group clock enable 1 |
| aclr0 | input | 1 | Group asynchronous clear 0, active high |
| aclr1 | input | 1 | Group asynchronous clear 1, active high |
| aload | input | 1 | Group asynchronous preset or load, active high |
| sclr | input | 1 | Group synchronous clear |
| sload | input | 1 | Group synchronous load of din[2] |
| sub_mode | input | 1 | Group add (0) or subtract (1) select |
| din | input | 4 | Cell data inputs |
| cin | input | 1 | Carry from the previous cell |
| cfg | input | 23 | Configuration word: [15:0] truth table, [16] arithmetic, [17] first stage, [18] clock select, [19] enable select, [20] clear select, [21] aload mode, [22] registered output |
| comb_o | output | 1 | Combinational result |
| reg_o | output | 1 | Registered result |
| cell_o | output | 1 | Selected cell output |
| cout_o | output | 1 | Carry to the next cell |

## Verification
comb_o, cout_o and cell_o follow their inputs in the same cycle. The bench therefore drives data on a falling clk0 edge and samples them 2 ns later, before any rising edge. reg_o changes on the first rising edge of the selected clock after the stimulus. So register checks drive on one falling edge and sample on the next one, which leaves exactly one capture edge in between. For clk1 a pulse is placed inside the low half of clk0. The asynchronous clear, preset and load act without a clock, so they are checked 2 ns after the control changes. They are checked again after a following edge, to confirm that they still win over capture.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

    // Number of table inputs and the resulting truth-table width.
    localparam int LUT_K = 4;
    localparam int LUT_W = 1 << LUT_K;

    // Group-wide signals that come in pairs and are picked per cell.
    typedef enum logic {PICK_0 = 1'b0, PICK_1 = 1'b1} pair_pick_e;

    // Behaviour of the shared asynchronous line.
    typedef enum logic {AL_PRESET = 1'b0, AL_LOAD = 1'b1} aload_mode_e;

    // Configuration word. The first field sits in the most significant bit.
    typedef struct packed {
        logic              out_reg;   // 1: cell output is registered
        aload_mode_e       al_mode;   // preset or asynchronous load
        pair_pick_e        clr_pick;  // which asynchronous clear
        pair_pick_e        ena_pick;  // which clock enable
        pair_pick_e        clk_pick;  // which clock
        logic              chain_head;// first stage of a carry chain
        logic              arith;     // arithmetic instead of table lookup
        logic [LUT_W-1:0]  table_bits;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

    // Result bundle of the arithmetic stage.
    typedef struct packed {
        logic sum;
        logic carry;
    } arith_res_t;

    // Chooses one of a pair of shared signals.
    function automatic logic pick_pair(input pair_pick_e p, input logic s0, input logic s1);
        return (p == PICK_1) ? s1 : s0;
    endfunction

endpackage

// File: rtl/lut_cell_table.sv
module lut_cell_table
    import lut_cell_pkg::*;
#(
    parameter int K = LUT_K
) (
    input  logic [(1<<K)-1:0] table_bits,
    input  logic [K-1:0]      sel,
    output logic              y
);
    localparam int W = 1 << K;

    // stage[K] holds the table; every stage above it halves the width by
    // resolving one select bit. The LSB resolves first, the MSB last.
    logic [W-1:0] stage [K+1];

    assign stage[K] = table_bits;

    for (genvar lv = K - 1; lv >= 0; lv--) begin : g_level
        localparam int NODES = 1 << lv;
        for (genvar n = 0; n < NODES; n++) begin : g_node
            assign stage[lv][n] = sel[K-1-lv] ? stage[lv+1][2*n+1] : stage[lv+1][2*n];
        end
        if (NODES < W) begin : g_pad
            assign stage[lv][W-1:NODES] = '0;
        end
    end

    assign y = stage[0][0];

endmodule

// File: rtl/lut_cell_carry.sv
module lut_cell_carry
    import lut_cell_pkg::*;
(
    input  logic       op_a,
    input  logic       op_b,
    input  logic       cin,
    input  logic       sub,
    input  logic       chain_head,
    output arith_res_t res
);
    logic b_eff;
    logic c_eff;
    arith_res_t cand0;   // result assuming carry-in 0
    arith_res_t cand1;   // result assuming carry-in 1

    // Subtraction adds the inverted operand. A chain head injects the +1
    // of two's complement itself and ignores the incoming carry.
    assign b_eff = op_b ^ sub;
    assign c_eff = chain_head ? sub : cin;

    always_comb begin
        cand0.sum   = op_a ^ b_eff;
        cand0.carry = op_a & b_eff;
        cand1.sum   = ~(op_a ^ b_eff);
        cand1.carry = op_a | b_eff;
    end

    // Late-arriving carry only drives the final select.
    assign res = c_eff ? cand1 : cand0;

endmodule

// File: rtl/lut_cell_ff.sv
module lut_cell_ff (
    input  logic clk,
    input  logic rst,
    input  logic aclr,
    input  logic aset,
    input  logic aset_val,
    input  logic sclr,
    input  logic sload,
    input  logic sload_val,
    input  logic ena,
    input  logic d,
    output logic q
);
    // Ranking: async clear, async set/load, reset, sync clear,
    // sync load, enabled capture.
    always_ff @(posedge clk or posedge aclr or posedge aset) begin
        if (aclr)       q <= 1'b0;
        else if (aset)  q <= aset_val;
        else if (rst)   q <= 1'b0;
        else if (sclr)  q <= 1'b0;
        else if (sload) q <= sload_val;
        else if (ena)   q <= d;
    end

endmodule

// File: rtl/lut_cell.sv
module lut_cell
    import lut_cell_pkg::*;
(
    input  logic             clk0,
    input  logic             clk1,
    input  logic             rst,
    input  logic             ena0,
    input  logic             ena1,
    input  logic             aclr0,
    input  logic             aclr1,
    input  logic             aload,
    input  logic             sclr,
    input  logic             sload,
    input  logic             sub_mode,
    input  logic [LUT_K-1:0] din,
    input  logic             cin,
    input  logic [CFG_W-1:0] cfg,
    output logic             comb_o,
    output logic             reg_o,
    output logic             cell_o,
    output logic             cout_o
);
    cell_cfg_t  c;
    logic       lut_y;
    arith_res_t ar;
    logic       clk_g;
    logic       ena_g;
    logic       clr_g;
    logic       aset_val;

    assign c = cell_cfg_t'(cfg);

    lut_cell_table #(.K(LUT_K)) u_table (
        .table_bits (c.table_bits),
        .sel        (din),
        .y          (lut_y)
    );

    lut_cell_carry u_carry (
        .op_a       (din[0]),
        .op_b       (din[1]),
        .cin        (cin),
        .sub        (sub_mode),
        .chain_head (c.chain_head),
        .res        (ar)
    );

    assign comb_o = c.arith ? ar.sum : lut_y;
    assign cout_o = ar.carry;

    // Per-cell picks from the shared pairs.
    assign clk_g = pick_pair(c.clk_pick, clk0, clk1);
    assign ena_g = pick_pair(c.ena_pick, ena0, ena1);
    assign clr_g = pick_pair(c.clr_pick, aclr0, aclr1);
    assign aset_val = (c.al_mode == AL_LOAD) ? din[3] : 1'b1;

    lut_cell_ff u_ff (
        .clk       (clk_g),
        .rst       (rst),
        .aclr      (clr_g),
        .aset      (aload),
        .aset_val  (aset_val),
        .sclr      (sclr),
        .sload     (sload),
        .sload_val (din[2]),
        .ena       (ena_g),
        .d         (comb_o),
        .q         (reg_o)
    );

    assign cell_o = c.out_reg ? reg_o : comb_o;

endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk
    import lut_cell_pkg::*;
(
    input logic             clk0,
    input logic             clk1,
    input logic             rst,
    input logic             ena0,
    input logic             ena1,
    input logic             aclr0,
    input logic             aclr1,
    input logic             aload,
    input logic             sclr,
    input logic             sload,
    input logic             sub_mode,
    input logic [LUT_K-1:0] din,
    input logic             cin,
    input logic [CFG_W-1:0] cfg,
    input logic             comb_o,
    input logic             reg_o,
    input logic             cell_o,
    input logic             cout_o
);
    // Expected values derived from the ports alone.
    logic k_arith, k_head, k_clk1, k_clr1, k_load;
    logic clr_sel, b_x, c_x, sum_x, cy_x;

    assign k_arith = cfg[16];
    assign k_head  = cfg[17];
    assign k_clk1  = cfg[18];
    assign k_clr1  = cfg[20];
    assign k_load  = cfg[21];
    assign clr_sel = k_clr1 ? aclr1 : aclr0;
    assign b_x     = din[1] ^ sub_mode;
    assign c_x     = k_head ? sub_mode : cin;
    assign sum_x   = din[0] ^ b_x ^ c_x;
    assign cy_x    = (din[0] & b_x) | (din[0] & c_x) | (b_x & c_x);

    AST_TABLE_LOOKUP: assert property (@(posedge clk0) disable iff (rst)
        !k_arith |-> comb_o == cfg[din]);  // R1

    AST_ARITH_SUM: assert property (@(posedge clk0) disable iff (rst)
        k_arith |-> comb_o == sum_x);  // R2

    AST_CARRY_OUT: assert property (@(posedge clk0) disable iff (rst)
        cout_o == cy_x);  // R3

    AST_CLEAR_WINS: assert property (@(posedge clk0) disable iff (rst)
        clr_sel |-> !reg_o);  // R7

    AST_ALOAD_VALUE: assert property (@(posedge clk0) disable iff (rst)
        (aload && !clr_sel) |-> reg_o == (k_load ? din[3] : 1'b1));  // R8

    AST_SYNC_CLEAR: assert property (@(posedge clk0) disable iff (rst)
        (!k_clk1 && sclr && !clr_sel && !aload) |=> (clr_sel || aload || !reg_o));  // R9

    AST_HOLD_NO_ENABLE: assert property (@(posedge clk0) disable iff (rst)
        (!k_clk1 && !ena0 && !ena1 && !sclr && !sload && !clr_sel && !aload)
        |=> (clr_sel || aload || $stable(reg_o)));  // R5

    AST_OUT_PICK: assert property (@(posedge clk0) disable iff (rst)
        cfg[22] |-> cell_o == reg_o);  // R11

endmodule

bind lut_cell lut_cell_chk u_chk (.*);

// File: tb/sim_lut_cell.sv
`timescale 1ns/1ps
module sim_lut_cell;
    import lut_cell_pkg::*;

    logic clk0 = 1'b0, clk1 = 1'b0, rst = 1'b1;
    logic ena0 = 0, ena1 = 0, aclr0 = 0, aclr1 = 0, aload = 0;
    logic sclr = 0, sload = 0, sub_mode = 0, cin = 0;
    logic [3:0] din = '0;
    logic [CFG_W-1:0] cfg = '0;
    logic comb_o, reg_o, cell_o, cout_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk0 = ~clk0;   // 50 MHz

    lut_cell u0 (.*);

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, got, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Config helper: table, arith, head, clk, ena, clr, aload mode, out_reg
    function automatic logic [CFG_W-1:0] mk(input logic [15:0] t, input logic ar,
        input logic hd, input logic ck, input logic en, input logic cl,
        input logic am, input logic orr);
        return {orr, am, cl, en, ck, hd, ar, t};
    endfunction

    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // Reset state (R12)
        @(negedge clk0);
        @(negedge clk0);
        chk(reg_o, 1'b0, "R12 reset");
        rst = 0;

        // R1 / R11: one-hot tables swept over every input pattern
        for (int k = 0; k < 16; k++) begin
            cfg = mk(16'(1 << k), 0, 0, 0, 0, 0, 0, 0);
            for (int v = 0; v < 16; v++) begin
                din = 4'(v);
                #2;
                chk(comb_o, (v == k), "R1 lookup");
                chk(cell_o, comb_o, "R11 comb out");
            end
        end
        cfg = mk(16'h6996, 0, 0, 0, 0, 0, 0, 0);
        for (int v = 0; v < 16; v++) begin
            din = 4'(v);
            #2;
            chk(comb_o, ^din, "R1 parity table");
        end

        // R2 R3 R4: arithmetic sweep
        for (int hd = 0; hd < 2; hd++)
            for (int sb = 0; sb < 2; sb++)
                for (int v = 0; v < 8; v++) begin
                    logic a, b, ci, bx, cx;
                    a = v[0]; b = v[1]; ci = v[2];
                    cfg = mk(16'h0000, 1, 1'(hd), 0, 0, 0, 0, 0);
                    sub_mode = 1'(sb);
                    din = {2'b00, b, a};
                    cin = ci;
                    #2;
                    bx = b ^ sub_mode;
                    cx = hd ? sub_mode : ci;
                    if (hd == 1) begin
                        chk(comb_o, a ^ bx ^ cx, "R4 head sum");
                        chk(cout_o, (a & bx) | (a & cx) | (bx & cx), "R4 head carry");
                    end else if (sb == 1) begin
                        chk(comb_o, a ^ bx ^ cx, "R3 sub sum");
                        chk(cout_o, (a & bx) | (a & cx) | (bx & cx), "R3 sub carry");
                    end else begin
                        chk(comb_o, a ^ bx ^ cx, "R2 add sum");
                        chk(cout_o, (a & bx) | (a & cx) | (bx & cx), "R2 add carry");
                    end
                end
        sub_mode = 0; cin = 0;

        // R5: capture through the parity table with ena0
        @(negedge clk0);
        cfg = mk(16'h6996, 0, 0, 0, 0, 0, 0, 0);
        ena0 = 1;
        for (int v = 0; v < 16; v++) begin
            din = 4'(v);
            @(negedge clk0);
            chk(reg_o, ^v[3:0], "R5 capture");
        end
        ena0 = 0; ena1 = 1; din = 4'b0001;
        @(negedge clk0);
        chk(reg_o, 1'b0, "R5 hold unselected enable");
        cfg = mk(16'h6996, 0, 0, 0, 1, 0, 0, 0);
        @(negedge clk0);
        chk(reg_o, 1'b1, "R5 capture ena1");
        cfg = mk(16'h6996, 0, 0, 0, 0, 0, 0, 0);
        ena0 = 1; ena1 = 0;

        // R6: clock select
        cfg = mk(16'h6996, 0, 0, 1, 0, 0, 0, 0);
        din = 4'b0011;
        @(negedge clk0);
        chk(reg_o, 1'b1, "R6 clk0 ignored");
        #2 clk1 = 1;
        #3 clk1 = 0;
        #2;
        chk(reg_o, 1'b0, "R6 clk1 edge");
        cfg = mk(16'h6996, 0, 0, 0, 0, 0, 0, 0);

        // R7: asynchronous clear
        din = 4'b0001;
        @(negedge clk0);
        chk(reg_o, 1'b1, "R5 setup");
        aclr1 = 1;
        #2;
        chk(reg_o, 1'b1, "R7 unselected clear");
        aclr1 = 0;
        aclr0 = 1;
        #2;
        chk(reg_o, 1'b0, "R7 clear");
        aload = 1;
        #2;
        chk(reg_o, 1'b0, "R7 clear over preset");
        @(negedge clk0);
        chk(reg_o, 1'b0, "R7 clear over capture");
        aload = 0;
        aclr0 = 0;
        @(negedge clk0);
        chk(reg_o, 1'b1, "R5 after clear");

        // R8: preset mode
        din = 4'b0000;
        @(negedge clk0);
        chk(reg_o, 1'b0, "R5 setup");
        aload = 1;
        #2;
        chk(reg_o, 1'b1, "R8 preset");
        @(negedge clk0);
        chk(reg_o, 1'b1, "R8 preset over capture");
        aload = 0;
        @(negedge clk0);
        chk(reg_o, 1'b0, "R5 after preset");

        // R8: asynchronous load mode
        cfg = mk(16'h6996, 0, 0, 0, 0, 0, 1, 0);
        din = 4'b1001;
        aload = 1;
        #2;
        chk(reg_o, 1'b1, "R8 load one");
        @(negedge clk0);
        chk(reg_o, 1'b1, "R8 load over capture");
        aload = 0;
        @(negedge clk0);
        chk(reg_o, 1'b0, "R5 after load");
        din = 4'b0111;
        @(negedge clk0);
        chk(reg_o, 1'b1, "R5 setup");
        din = 4'b0110;
        aload = 1;
        #2;
        chk(reg_o, 1'b0, "R8 load zero");
        aload = 0;
        cfg = mk(16'h6996, 0, 0, 0, 0, 0, 0, 0);

        // R9 R10: synchronous clear and load
        @(negedge clk0);
        ena0 = 0;
        din = 4'b0100;
        sload = 1;
        @(negedge clk0);
        chk(reg_o, 1'b1, "R10 load without enable");
        sclr = 1;
        @(negedge clk0);
        chk(reg_o, 1'b0, "R9 clear over load");
        sload = 0;
        ena0 = 1;
        din = 4'b0001;
        @(negedge clk0);
        chk(reg_o, 1'b0, "R9 clear over capture");
        sclr = 0;
        @(negedge clk0);
        chk(reg_o, 1'b1, "R5 after sclr");
        din = 4'b1011;
        sload = 1;
        @(negedge clk0);
        chk(reg_o, 1'b0, "R10 load over capture");
        din = 4'b0100;
        @(negedge clk0);
        chk(reg_o, 1'b1, "R10 load one");
        rst = 1;
        @(negedge clk0);
        chk(reg_o, 1'b0, "R12 reset over load");
        rst = 0;
        sload = 0;

        // R11: registered output
        cfg = mk(16'h6996, 0, 0, 0, 0, 0, 0, 1);
        din = 4'b0001;
        @(negedge clk0);
        ena0 = 0;
        din = 4'b0000;
        #2;
        chk(comb_o, 1'b0, "R11 comb value");
        chk(cell_o, 1'b1, "R11 registered out");
        cfg = mk(16'h6996, 0, 0, 0, 0, 0, 0, 0);
        #2;
        chk(cell_o, 1'b0, "R11 comb out");

        @(negedge clk0);
        finish_run();
    end

endmodule